// File: doc/BRIEF.md
# Queue Head Descriptor Walker

This block walks the work queue of one endpoint for all transfer types other than isochronous. Each endpoint owns exactly one queue. The block holds the queue head itself, which has two parts. The static part is the endpoint information loaded at set-up. The dynamic part is an overlay that holds a working copy of the transfer descriptor currently in progress.

On each visit the walker follows the head's next pointer and reads the descriptor there in one burst. It then inspects the active flag. If the descriptor is live, the walker copies it into the overlay, and the head inherits the descriptor's own next pointer. The walker then presents the overlay to a transaction executor, which may run one or many bus transactions, and waits until the executor reports completion. Finally it writes the result back into the descriptor in memory with the active flag cleared.

Software appends work by writing a new descriptor and then linking it from the tail. No lock or handshake with the hardware is involved. This works because, when the head holds a terminated pointer, the walker re-reads the link word of the last descriptor it executed.

Top module: `qh_walker`

## Requirements
- R1: After reset the walker issues no memory request, presents no work, and its head holds a terminated pointer. A visit in that state produces `visit_done` with no memory access.
- R2: A `head_load` pulse while idle loads the head's next pointer from `head_ptr` and the endpoint information from `ep_info`. The endpoint information is then presented on `exec_ep` with every descriptor executed.
- R3: Descriptors occupy three consecutive words in this order: link, token, buffer pointer. A link has bit 31 set when it is terminated and carries the word address in bits [ADDR_W-1:0]. A token holds the byte count in bits [30:16], the active flag in bit 15 and the status in bits [7:0]. A descriptor fetch is a single read request with `mem_blen` = 3 at the linked address.
- R4: A fetched descriptor whose active flag is clear is not executed and not written. The visit ends, the head pointer is left unchanged, and the next visit fetches the same address again.
- R5: A fetched active descriptor is copied into the overlay. `exec_valid` rises with its byte count on `exec_bytes` and its buffer pointer on `exec_bptr`. The head's next pointer becomes that descriptor's link, so the following visit fetches from there.
- R6: On `exec_done`, one write (`mem_blen` = 1) goes to the descriptor's token word (address + 1). It carries `exec_left` in bits [30:16], the active flag cleared, and `exec_status` in bits [7:0]. `visit_done` pulses after the write is accepted.
- R7: If a visit starts with a terminated head pointer after at least one descriptor has been taken, the walker first reads one word, the link of the last descriptor taken. If that link is live, the walker fetches and processes the linked descriptor in the same visit. Otherwise the visit ends.
- R8: A descriptor byte count up to MAX_BYTES (20480) is executed. An active descriptor above that limit is never handed to the executor. It is written back with status 0x40 and the remaining count equal to its full byte count, and its link is still inherited.
- R9: A memory request that is not accepted (`mem_ready` low) stays asserted with unchanged address and direction until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_load | input | 1 | Load head pointer and endpoint information |
| head_ptr | input | 32 | Initial head link value |
| ep_info | input | EP_W | Static endpoint information |
| visit | input | 1 | Start one pass over the queue |
| visit_done | output | 1 | One-cycle pulse at the end of a pass |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_blen | output | 2 | Words in the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data word valid |
| mem_rdata | input | 32 | Read data word, in address order |
| exec_valid | output | 1 | Overlay presented to executor |
| exec_ep | output | EP_W | Endpoint information |
| exec_bytes | output | 15 | Descriptor byte count |
| exec_bptr | output | 32 | Descriptor buffer pointer |
| exec_done | input | 1 | Executor finished the descriptor |
| exec_status | input | 8 | Completion status |
| exec_left | input | 15 | Bytes not transferred |

## Verification
The hardest case to reach is the lock-free append. Software links a new descriptor onto a tail whose terminated link the head has already inherited. The walker must then recover the work by re-reading that tail's link rather than its own stale copy. The stimulus reaches this case in several steps. It first leaves a descriptor inactive so that the head stalls on it across two visits. It then activates that descriptor with an oversized count, which consumes it without execution. Next it runs one visit that finds nothing behind it. Only then does it write a new descriptor and patch the tail link between visits. A varying `mem_ready` pattern keeps requests waiting throughout, so that the hold rule is exercised on both reads and writes.

// File: rtl/qhw_pkg.sv
package qhw_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 3;
    localparam int LEN_W      = 15;
    localparam int STAT_W     = 8;
    localparam int TERM_BIT   = 31;
    localparam int ACT_BIT    = 15;
    localparam int LEN_LSB    = 16;
    localparam int BLEN_W     = $clog2(DESC_WORDS + 1);

    localparam logic [STAT_W-1:0] ST_OVERSIZE = 8'h40;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_NEXT,
        S_CHECK_ACTIVE,
        S_COPY_OVERLAY,
        S_EXECUTE,
        S_WRITEBACK
    } qstate_t;

    // word 0 (link) sits in the low bits
    typedef struct packed {
        logic [WORD_W-1:0] bptr;
        logic [WORD_W-1:0] tok;
        logic [WORD_W-1:0] nxt;
    } desc_t;

    function automatic logic ptr_term(input logic [WORD_W-1:0] w);
        return w[TERM_BIT];
    endfunction

    function automatic logic tok_active(input logic [WORD_W-1:0] w);
        return w[ACT_BIT];
    endfunction

    function automatic logic [LEN_W-1:0] tok_len(input logic [WORD_W-1:0] w);
        return w[LEN_LSB +: LEN_W];
    endfunction

    function automatic logic [WORD_W-1:0] mk_tok(input logic [LEN_W-1:0] len,
                                                 input logic [STAT_W-1:0] st);
        logic [WORD_W-1:0] t;
        t = '0;
        t[LEN_LSB +: LEN_W] = len;
        t[STAT_W-1:0]       = st;
        return t;
    endfunction

endpackage

// File: rtl/qhw_burst_rx.sv
module qhw_burst_rx #(
    parameter int NWORDS = 3,
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(NWORDS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     rvalid,
    input  logic [WORD_W-1:0]        rdata,
    output logic [NWORDS*WORD_W-1:0] words,
    output logic [CNT_W-1:0]         got
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            got <= '0;
        else if (rvalid && got < CNT_W'(NWORDS))
            got <= got + 1'b1;
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g*WORD_W +: WORD_W] <= '0;
            else if (!clear && rvalid && got == CNT_W'(g))
                words[g*WORD_W +: WORD_W] <= rdata;
        end
    end

endmodule

// File: rtl/qhw_req_mux.sv
module qhw_req_mux #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    localparam int BLEN_W = $clog2(NWORDS + 1)
) (
    input  logic              rd_go,
    input  logic              wr_go,
    input  logic              refresh,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] wb_word,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [BLEN_W-1:0] blen,
    output logic [WORD_W-1:0] wdata
);

    always_comb begin
        req   = rd_go || wr_go;
        we    = wr_go;
        wdata = wb_word;
        if (wr_go) begin
            addr = cur_addr + ADDR_W'(1);
            blen = BLEN_W'(1);
        end else if (refresh) begin
            addr = cur_addr;
            blen = BLEN_W'(1);
        end else begin
            addr = next_addr;
            blen = BLEN_W'(NWORDS);
        end
    end

endmodule

// File: rtl/qh_walker.sv
module qh_walker
    import qhw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int EP_W      = 16,
    parameter int MAX_BYTES = 20480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_load,
    input  logic [31:0]       head_ptr,
    input  logic [EP_W-1:0]   ep_info,
    input  logic              visit,
    output logic              visit_done,
    output logic              mem_req,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_blen,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              exec_valid,
    output logic [EP_W-1:0]   exec_ep,
    output logic [14:0]       exec_bytes,
    output logic [31:0]       exec_bptr,
    input  logic              exec_done,
    input  logic [7:0]        exec_status,
    input  logic [14:0]       exec_left
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);

    qstate_t             state;
    logic [WORD_W-1:0]   qh_next;
    logic [ADDR_W-1:0]   cur_addr;
    logic                have_cur, refresh, sent, done_r;
    logic [EP_W-1:0]     ep_r;
    logic [LEN_W-1:0]    ovl_len;
    logic [WORD_W-1:0]   ovl_bptr;
    logic [WORD_W-1:0]   wb_tok;

    logic [DESC_WORDS*WORD_W-1:0] rx_flat;
    logic [BLEN_W-1:0]            rx_got;
    desc_t                        rx_d;
    logic                         rx_clear, oversize;
    logic [BLEN_W-1:0]            need;
    logic                         walk_unused;

    assign rx_d     = rx_flat;
    assign rx_clear = (state == S_FETCH_NEXT) && !sent;
    assign need     = refresh ? BLEN_W'(1) : BLEN_W'(DESC_WORDS);
    assign oversize = tok_len(rx_d.tok) > MAX_LEN;
    assign walk_unused = ^{rx_flat, qh_next};

    qhw_burst_rx #(.NWORDS(DESC_WORDS), .WORD_W(WORD_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .clear (rx_clear),
        .rvalid(mem_rvalid),
        .rdata (mem_rdata),
        .words (rx_flat),
        .got   (rx_got)
    );

    qhw_req_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NWORDS(DESC_WORDS)) u_mux (
        .rd_go    (rx_clear),
        .wr_go    (state == S_WRITEBACK),
        .refresh  (refresh),
        .next_addr(qh_next[ADDR_W-1:0]),
        .cur_addr (cur_addr),
        .wb_word  (wb_tok),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr),
        .blen     (mem_blen),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            qh_next  <= 32'h8000_0000;
            cur_addr <= '0;
            have_cur <= 1'b0;
            refresh  <= 1'b0;
            sent     <= 1'b0;
            done_r   <= 1'b0;
            ep_r     <= '0;
            ovl_len  <= '0;
            ovl_bptr <= '0;
            wb_tok   <= '0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (head_load) begin
                        qh_next  <= head_ptr;
                        ep_r     <= ep_info;
                        have_cur <= 1'b0;
                    end else if (visit) begin
                        if (ptr_term(qh_next) && !have_cur) begin
                            done_r <= 1'b1;
                        end else begin
                            state   <= S_FETCH_NEXT;
                            refresh <= ptr_term(qh_next);
                            sent    <= 1'b0;
                        end
                    end
                end
                S_FETCH_NEXT: begin
                    if (!sent) begin
                        if (mem_ready) sent <= 1'b1;
                    end else if (rx_got == need) begin
                        if (refresh) begin
                            qh_next <= rx_d.nxt;
                            refresh <= 1'b0;
                            sent    <= 1'b0;
                            if (ptr_term(rx_d.nxt)) begin
                                state  <= S_IDLE;
                                done_r <= 1'b1;
                            end
                        end else begin
                            state <= S_CHECK_ACTIVE;
                        end
                    end
                end
                S_CHECK_ACTIVE: begin
                    if (tok_active(rx_d.tok)) begin
                        state <= S_COPY_OVERLAY;
                    end else begin
                        state  <= S_IDLE;
                        done_r <= 1'b1;
                    end
                end
                S_COPY_OVERLAY: begin
                    ovl_len  <= tok_len(rx_d.tok);
                    ovl_bptr <= rx_d.bptr;
                    cur_addr <= qh_next[ADDR_W-1:0];
                    have_cur <= 1'b1;
                    qh_next  <= rx_d.nxt;
                    if (oversize) begin
                        wb_tok <= mk_tok(tok_len(rx_d.tok), ST_OVERSIZE);
                        state  <= S_WRITEBACK;
                    end else begin
                        state  <= S_EXECUTE;
                    end
                end
                S_EXECUTE: begin
                    if (exec_done) begin
                        wb_tok <= mk_tok(exec_left, exec_status);
                        state  <= S_WRITEBACK;
                    end
                end
                S_WRITEBACK: begin
                    if (mem_ready) begin
                        state  <= S_IDLE;
                        done_r <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign visit_done = done_r;
    assign exec_valid = (state == S_EXECUTE);
    assign exec_ep    = ep_r;
    assign exec_bytes = ovl_len;
    assign exec_bptr  = ovl_bptr;

    // ---- assertions ----
    p_exec_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> exec_bytes <= MAX_LEN);

    p_wb_clears_active_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[ACT_BIT]);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_len_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_blen == 2'd1 || mem_blen == 2'(DESC_WORDS)));

    p_no_req_while_exec_r5: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> !mem_req);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        visit_done |=> !visit_done);

endmodule

// File: tb/sim_qh_walker.sv
module sim_qh_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        head_load = 1'b0;
    logic [31:0] head_ptr = '0;
    logic [15:0] ep_info = '0;
    logic        visit = 1'b0;
    logic        visit_done;
    logic        mem_req, mem_we;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_addr;
    logic [1:0]  mem_blen;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        exec_valid;
    logic [15:0] exec_ep;
    logic [14:0] exec_bytes;
    logic [31:0] exec_bptr;
    logic        exec_done = 1'b0;
    logic [7:0]  exec_status = '0;
    logic [14:0] exec_left = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qh_walker u0 (
        .clk(clk), .rst(rst), .head_load(head_load), .head_ptr(head_ptr),
        .ep_info(ep_info), .visit(visit), .visit_done(visit_done),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_blen(mem_blen), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .exec_valid(exec_valid), .exec_ep(exec_ep), .exec_bytes(exec_bytes),
        .exec_bptr(exec_bptr), .exec_done(exec_done),
        .exec_status(exec_status), .exec_left(exec_left)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:63];
    int rsp_q[$];
    int exp_rd_addr[$];
    int exp_rd_len[$];
    int exp_wr_addr[$];
    logic [31:0] exp_wr_data[$];
    int exp_ex_bytes[$];
    logic [31:0] exp_ex_bptr[$];

    logic [31:0] m_next;
    int          m_cur;
    bit          m_have;
    logic [15:0] m_ep;

    int  cyc = 0;
    bit  hold_p = 0;
    logic [15:0] hold_a;
    int  ex_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tok(input int bytes, input bit act);
        return (32'(bytes) << 16) | (32'(act) << 15);
    endfunction

    function automatic logic [31:0] wb(input int left, input logic [7:0] st);
        return (32'(left) << 16) | 32'(st);
    endfunction

    // reference walk over the bench memory image
    task automatic predict_visit();
        int a, bytes;
        if (m_next[31]) begin
            if (!m_have) return;
            exp_rd_addr.push_back(m_cur); exp_rd_len.push_back(1);
            m_next = mem[m_cur];
            if (m_next[31]) return;
        end
        a = int'(m_next[15:0]);
        exp_rd_addr.push_back(a); exp_rd_len.push_back(3);
        if (!mem[a+1][15]) return;
        bytes  = int'(mem[a+1][30:16]);
        m_cur  = a;
        m_have = 1;
        m_next = mem[a];
        exp_wr_addr.push_back(a + 1);
        if (bytes > 20480) begin
            exp_wr_data.push_back(wb(bytes, 8'h40));
        end else begin
            exp_ex_bytes.push_back(bytes);
            exp_ex_bptr.push_back(mem[a+2]);
            exp_wr_data.push_back(wb(bytes >> 1, {4'h2, 4'(bytes)}));
        end
    endtask

    task automatic do_visit(input string req, input string tag);
        bit got_done;
        predict_visit();
        @(negedge clk);
        visit = 1'b1;
        got_done = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            visit = 1'b0;
            if (visit_done) begin
                got_done = 1;
                break;
            end
        end
        chk(got_done, req, {tag, " visit_done seen"}, 32'(got_done), 32'd1);
        chk(exp_rd_addr.size() == 0, req, {tag, " reads outstanding"},
            32'(exp_rd_addr.size()), 0);
        chk(exp_wr_addr.size() == 0, req, {tag, " writes outstanding"},
            32'(exp_wr_addr.size()), 0);
        chk(exp_ex_bytes.size() == 0, req, {tag, " executions outstanding"},
            32'(exp_ex_bytes.size()), 0);
        exp_rd_addr.delete(); exp_rd_len.delete();
        exp_wr_addr.delete(); exp_wr_data.delete();
        exp_ex_bytes.delete(); exp_ex_bptr.delete();
        repeat (2) @(negedge clk);
    endtask

    // memory and executor models, compared on every clock
    always @(negedge clk) begin
        bit rdy;
        cyc++;
        if (rst) begin
            mem_ready  = 1'b0;
            mem_rvalid = 1'b0;
        end else begin
            if (hold_p)
                chk(mem_req && mem_addr == hold_a, "R9", "held request",
                    {15'd0, mem_req, mem_addr}, {16'd1, hold_a});
            if (rsp_q.size() > 0) begin
                int a;
                a = rsp_q.pop_front();
                mem_rvalid = 1'b1;
                mem_rdata  = mem[a];
            end else begin
                mem_rvalid = 1'b0;
            end
            rdy = (cyc % 3) != 1;
            mem_ready = rdy;
            if (mem_req && rdy) begin
                if (mem_we) begin
                    if (exp_wr_addr.size() == 0) begin
                        chk(0, "R6", "unexpected write", 32'(mem_addr), 0);
                    end else begin
                        int ea;
                        logic [31:0] ed;
                        ea = exp_wr_addr.pop_front();
                        ed = exp_wr_data.pop_front();
                        chk(int'(mem_addr) == ea, "R6", "write address", 32'(mem_addr), 32'(ea));
                        chk(mem_wdata == ed, "R6", "write data", mem_wdata, ed);
                        chk(mem_blen == 2'd1, "R6", "write length", 32'(mem_blen), 1);
                    end
                    mem[mem_addr[5:0]] = mem_wdata;
                end else begin
                    if (exp_rd_addr.size() == 0) begin
                        chk(0, "R4", "unexpected read", 32'(mem_addr), 0);
                    end else begin
                        int ea, el;
                        ea = exp_rd_addr.pop_front();
                        el = exp_rd_len.pop_front();
                        chk(int'(mem_addr) == ea, "R5", "read address", 32'(mem_addr), 32'(ea));
                        chk(int'(mem_blen) == el, "R3", "read length", 32'(mem_blen), 32'(el));
                    end
                    for (int k = 0; k < int'(mem_blen); k++)
                        rsp_q.push_back(int'(mem_addr[5:0]) + k);
                end
            end
            hold_p = mem_req && !rdy;
            hold_a = mem_addr;

            if (exec_valid && !exec_done) begin
                ex_cnt++;
                if (ex_cnt == 1) begin
                    if (exp_ex_bytes.size() == 0) begin
                        chk(0, "R8", "unexpected execution", 32'(exec_bytes), 0);
                    end else begin
                        int eb;
                        logic [31:0] ep;
                        eb = exp_ex_bytes.pop_front();
                        ep = exp_ex_bptr.pop_front();
                        chk(int'(exec_bytes) == eb, "R5", "overlay bytes", 32'(exec_bytes), 32'(eb));
                        chk(exec_bptr == ep, "R5", "overlay buffer", exec_bptr, ep);
                        chk(exec_ep == m_ep, "R2", "endpoint info", 32'(exec_ep), 32'(m_ep));
                    end
                end
                if (ex_cnt == 3) begin
                    exec_done   = 1'b1;
                    exec_status = {4'h2, exec_bytes[3:0]};
                    exec_left   = exec_bytes >> 1;
                end
            end else begin
                exec_done = 1'b0;
                ex_cnt    = 0;
            end
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        m_next = 32'h8000_0000;
        m_have = 0;
        m_cur  = 0;
        m_ep   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req, "R1", "no request after reset", 32'(mem_req), 0);
        chk(!exec_valid, "R1", "no work after reset", 32'(exec_valid), 0);
        chk(!visit_done, "R1", "no done after reset", 32'(visit_done), 0);

        do_visit("R1", "empty head");

        // A -> B -> C chain
        mem[8]  = 32'd12; mem[9]  = tok(100, 1);   mem[10] = 32'h1000_0040;
        mem[12] = 32'd16; mem[13] = tok(20480, 1); mem[14] = 32'h2000_0000;
        mem[16] = 32'h8000_0000; mem[17] = tok(20481, 0); mem[18] = 32'h3000_0000;

        @(negedge clk);
        head_ptr  = 32'd8;
        ep_info   = 16'h1234;
        head_load = 1'b1;
        @(negedge clk);
        head_load = 1'b0;
        m_next = 32'd8;
        m_have = 0;
        m_ep   = 16'h1234;

        do_visit("R5", "first descriptor");
        chk(!mem[9][15], "R6", "active cleared in memory", mem[9], mem[9] & ~32'h8000);
        do_visit("R8", "byte count at limit");
        do_visit("R4", "inactive descriptor");
        do_visit("R4", "inactive descriptor re-read");

        mem[17] = tok(20481, 1);
        do_visit("R8", "oversized descriptor");
        chk(mem[17] == wb(20481, 8'h40), "R8", "oversize writeback", mem[17], wb(20481, 8'h40));

        do_visit("R7", "tail still terminated");

        // lock-free append behind the tail
        mem[20] = 32'h8000_0000; mem[21] = tok(7, 1); mem[22] = 32'h4000_0100;
        mem[16] = 32'd20;
        do_visit("R7", "appended descriptor");
        chk(mem[21] == wb(3, 8'h27), "R6", "appended writeback", mem[21], wb(3, 8'h27));
        do_visit("R7", "after append");

        report();
    end

endmodule